// File: doc/BRIEF.md
# Lane Start-up Sequencer

This block drives the transmit side of one serial lane while the link is being brought up. An active-low synchronization request from the receiver sets its behaviour. While the request is low, the lane carries nothing but comma control characters. This lets the receiver find bit and octet boundaries. When the request goes high, the block sends an alignment preamble of exactly four multiframes. It then passes the payload octet stream through unchanged.

A multiframe is `FRAME_OCTETS * (kMinus1 + 1)` octets long. Each multiframe is framed by a start marker and an end marker. A receiver can use these markers to bond several lanes. The second multiframe also carries a marker that announces the configuration data, followed by the link parameter table octet by octet. The preamble starts a fixed number of cycles after the first high sample of the request. Every lane that shares the request therefore starts at the same pipeline depth. Raising the request again at any time sends the lane back to commas.

The output is one octet per clock, with a flag that marks control characters. Line coding, scrambling and the physical layer sit outside this block.

Top module: `lane_init_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the output is the comma 0xBC with the control flag 1, and payloadTake is 0.
- R2: When syncN is sampled low at a clock edge, the output after that edge is the comma 0xBC with the control flag 1, whatever the sequence state.
- R3: When syncN is first sampled high after being low (edge e0), the output after e0 is still a comma. The outputs after edges e1 through e(4L) are the four alignment multiframes, with L = FRAME_OCTETS*(kMinus1+1) octets each, sent in order.
- R4: In every alignment multiframe, position 0 is the start marker 0x1C and position L-1 is the end marker 0x7C, both with the control flag 1. When both rules apply to the same position, the start marker wins.
- R5: In the second multiframe only, position 1 is the configuration marker 0x9C with the control flag 1. Positions 2 to 1+NUM_PARAMS carry parameter byte p-2, where byte i is paramTbl[8i+7:8i], with the control flag 0. The end marker takes priority over both.
- R6: Every other alignment position p carries the filler octet p mod 256 with the control flag 0.
- R7: kMinus1 is captured at edge e0. Changes to it while the preamble is running have no effect on the multiframe length.
- R8: payloadTake is 1 from the cycle in which the last end marker is on the output, for as long as syncN stays high. After each edge at which payloadTake is 1, the output is the payIn value sampled at that edge, with the control flag 0.
- R9: The control flag is 1 only together with one of the octets 0xBC, 0x1C, 0x7C or 0x9C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one octet per cycle |
| rst | input | 1 | Synchronous reset, active high |
| syncN | input | 1 | Synchronization request from the receiver, active low |
| kMinus1 | input | KW | Frames per multiframe, minus one |
| paramTbl | input | 8*NUM_PARAMS | Link parameter table; byte i is bits 8i+7 to 8i |
| payIn | input | 8 | Payload octet stream |
| octOut | output | 8 | Lane octet |
| ctrlOut | output | 1 | High when octOut is a control character |
| payloadTake | output | 1 | High when payIn is taken at the next edge |

## Verification
The preamble is checked octet by octet for every multiframe length in the small bench configuration. The shortest lengths hide the configuration marker, and part of the parameter table, behind the end marker, which shows whether the marker priorities are right. The longest lengths expose the whole table and the filler ramp. Payload is a changing ramp, so a one-cycle skew in the pass-through is caught. Separate runs drop the request in the middle of the preamble and in the middle of payload, and change kMinus1 just after the start edge. These runs show whether the block returns to commas at once and whether the multiframe length stays at the value captured at the start edge.

// File: rtl/lis_pkg.sv
package lis_pkg;
  localparam logic [7:0] SYM_COMMA = 8'hBC;
  localparam logic [7:0] SYM_START = 8'h1C;
  localparam logic [7:0] SYM_END   = 8'h7C;
  localparam logic [7:0] SYM_CFG   = 8'h9C;

  typedef enum logic [1:0] {
    ST_COMMA   = 2'd0,
    ST_ALIGN   = 2'd1,
    ST_PAYLOAD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic       selComma;
    logic       selStart;
    logic       selCfg;
    logic       selEnd;
    logic       selParam;
    logic       selData;
    logic [7:0] paramIdx;
    logic [7:0] fillOct;
  } seqStrobe_t;
endpackage

// File: rtl/lis_ctrl.sv
module lis_ctrl
  import lis_pkg::*;
#(
  parameter int FRAME_OCTETS = 2,
  parameter int NUM_PARAMS   = 14,
  parameter int KW           = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          syncN,
  input  logic [KW-1:0] kMinus1,
  output seqStrobe_t    strobe,
  output logic          payloadTake
);
  localparam int MF_MAX = FRAME_OCTETS * (1 << KW);
  localparam int POSW   = (MF_MAX > 1) ? $clog2(MF_MAX) : 1;

  seqState_t        state;
  logic [POSW-1:0]  pos;
  logic [POSW-1:0]  lastPos;
  logic [1:0]       mfIdx;
  logic [POSW:0]    lenCalc;
  logic [POSW-1:0]  lastCalc;

  always_comb begin
    lenCalc  = (POSW+1)'(FRAME_OCTETS * (int'(kMinus1) + 1));
    lastCalc = POSW'(lenCalc - (POSW+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_COMMA;
      pos     <= '0;
      mfIdx   <= '0;
      lastPos <= '0;
    end else if (!syncN) begin
      state <= ST_COMMA;
      pos   <= '0;
      mfIdx <= '0;
    end else begin
      case (state)
        ST_COMMA: begin
          state   <= ST_ALIGN;
          pos     <= '0;
          mfIdx   <= '0;
          lastPos <= lastCalc;
        end
        ST_ALIGN: begin
          if (pos == lastPos) begin
            pos <= '0;
            if (mfIdx == 2'd3) state <= ST_PAYLOAD;
            else mfIdx <= mfIdx + 2'd1;
          end else begin
            pos <= pos + POSW'(1);
          end
        end
        ST_PAYLOAD: state <= ST_PAYLOAD;
        default:    state <= ST_COMMA;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.fillOct  = 8'(pos);
    if (!syncN || state == ST_COMMA) begin
      strobe.selComma = 1'b1;
    end else if (state == ST_PAYLOAD) begin
      strobe.selData = 1'b1;
    end else if (pos == '0) begin
      strobe.selStart = 1'b1;
    end else if (pos == lastPos) begin
      strobe.selEnd = 1'b1;
    end else if (mfIdx == 2'd1 && int'(pos) == 1) begin
      strobe.selCfg = 1'b1;
    end else if (mfIdx == 2'd1 && int'(pos) >= 2 && int'(pos) < 2 + NUM_PARAMS) begin
      strobe.selParam = 1'b1;
      strobe.paramIdx = 8'(int'(pos) - 2);
    end
  end

  assign payloadTake = syncN && (state == ST_PAYLOAD);
endmodule

// File: rtl/lis_datapath.sv
module lis_datapath
  import lis_pkg::*;
#(
  parameter int NUM_PARAMS = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobe_t            strobe,
  input  logic [8*NUM_PARAMS-1:0] paramTbl,
  input  logic [7:0]            payIn,
  output logic [7:0]            octOut,
  output logic                  ctrlOut
);
  logic [7:0] paramByte;
  logic [7:0] nextOct;
  logic       nextCtrl;

  always_comb begin
    paramByte = '0;
    for (int i = 0; i < NUM_PARAMS; i++) begin
      if (strobe.paramIdx == 8'(i)) paramByte = paramTbl[8*i +: 8];
    end
  end

  always_comb begin
    nextCtrl = 1'b1;
    if (strobe.selComma)      nextOct = SYM_COMMA;
    else if (strobe.selStart) nextOct = SYM_START;
    else if (strobe.selEnd)   nextOct = SYM_END;
    else if (strobe.selCfg)   nextOct = SYM_CFG;
    else begin
      nextCtrl = 1'b0;
      if (strobe.selData)       nextOct = payIn;
      else if (strobe.selParam) nextOct = paramByte;
      else                      nextOct = strobe.fillOct;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      octOut  <= SYM_COMMA;
      ctrlOut <= 1'b1;
    end else begin
      octOut  <= nextOct;
      ctrlOut <= nextCtrl;
    end
  end
endmodule

// File: rtl/lane_init_seq.sv
module lane_init_seq
  import lis_pkg::*;
#(
  parameter int FRAME_OCTETS = 2,
  parameter int NUM_PARAMS   = 14,
  parameter int KW           = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    syncN,
  input  logic [KW-1:0]           kMinus1,
  input  logic [8*NUM_PARAMS-1:0] paramTbl,
  input  logic [7:0]              payIn,
  output logic [7:0]              octOut,
  output logic                    ctrlOut,
  output logic                    payloadTake
);
  seqStrobe_t seqStrobe;

  lis_ctrl #(
    .FRAME_OCTETS(FRAME_OCTETS),
    .NUM_PARAMS  (NUM_PARAMS),
    .KW          (KW)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .syncN      (syncN),
    .kMinus1    (kMinus1),
    .strobe     (seqStrobe),
    .payloadTake(payloadTake)
  );

  lis_datapath #(
    .NUM_PARAMS(NUM_PARAMS)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (seqStrobe),
    .paramTbl(paramTbl),
    .payIn   (payIn),
    .octOut  (octOut),
    .ctrlOut (ctrlOut)
  );
endmodule

// File: rtl/lane_init_seq_chk.sv
module lane_init_seq_chk
  import lis_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       syncN,
  input logic [7:0] payIn,
  input logic [7:0] octOut,
  input logic       ctrlOut,
  input logic       payloadTake,
  input seqStrobe_t seqStrobe
);
  // R2: a low request forces a comma on the next output
  a_r2_comma_on_request: assert property (@(posedge clk) disable iff (rst)
    !syncN |=> (octOut == SYM_COMMA && ctrlOut));

  // R3: start marker follows two high samples after a low one
  a_r3_start_after_release: assert property (@(posedge clk) disable iff (rst)
    ($rose(syncN) ##1 syncN) |=> (octOut == SYM_START && ctrlOut));

  // R8: payload passes through one cycle later as data
  a_r8_payload_passthru: assert property (@(posedge clk) disable iff (rst)
    payloadTake |=> (octOut == $past(payIn) && !ctrlOut));

  // R9: control flag only with the four control codes
  a_r9_ctrl_codes: assert property (@(posedge clk) disable iff (rst)
    ctrlOut |-> (octOut == SYM_COMMA || octOut == SYM_START ||
                 octOut == SYM_END   || octOut == SYM_CFG));

  // R4: at most one octet source is chosen from the control side
  a_r4_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({seqStrobe.selComma, seqStrobe.selStart, seqStrobe.selCfg,
              seqStrobe.selEnd, seqStrobe.selParam, seqStrobe.selData}));
endmodule

bind lane_init_seq lane_init_seq_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .syncN      (syncN),
  .payIn      (payIn),
  .octOut     (octOut),
  .ctrlOut    (ctrlOut),
  .payloadTake(payloadTake),
  .seqStrobe  (seqStrobe)
);

// File: tb/test_lane_init_seq.sv
module test_lane_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FO = 2;
  localparam int NP = 4;
  localparam int KWB = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            syncN = 1'b0;
  logic [KWB-1:0]  kMinus1 = '0;
  logic [8*NP-1:0] paramTbl = 32'hD4C3B2A1;
  logic [7:0]      payIn = 8'h00;
  logic [7:0]      octOut;
  logic            ctrlOut;
  logic            payloadTake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_init_seq #(.FRAME_OCTETS(FO), .NUM_PARAMS(NP), .KW(KWB)) i_lane_init_seq (
    .clk(clk), .rst(rst), .syncN(syncN), .kMinus1(kMinus1), .paramTbl(paramTbl),
    .payIn(payIn), .octOut(octOut), .ctrlOut(ctrlOut), .payloadTake(payloadTake)
  );

  task automatic chk(string req, logic [7:0] eo, logic ec, logic et);
    checks++;
    if (octOut !== eo || ctrlOut !== ec || payloadTake !== et) begin
      errors++;
      $display("FAIL %s: got oct=%h ctrl=%b take=%b, expected oct=%h ctrl=%b take=%b",
               req, octOut, ctrlOut, payloadTake, eo, ec, et);
    end
  endtask

  function automatic void alignOct(int j, int len, output logic [7:0] o, output logic c);
    int mf = j / len;
    int p  = j % len;
    c = 1'b1;
    if (p == 0)                            o = 8'h1C;
    else if (p == len - 1)                 o = 8'h7C;
    else if (mf == 1 && p == 1)            o = 8'h9C;
    else if (mf == 1 && p >= 2 && p < 2 + NP) begin
      o = paramTbl[8*(p-2) +: 8]; c = 1'b0;
    end else begin
      o = 8'(p); c = 1'b0;
    end
  endfunction

  // abortAt < 0: no abort; kNew >= 0: kMinus1 changed right after the start edge
  task automatic runSeq(int k, int abortAt, int kNew);
    int len = FO * (k + 1);
    logic [7:0] eo;
    logic ec;
    syncN = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R2 comma while request low", 8'hBC, 1'b1, 1'b0);
    end
    kMinus1 = KWB'(k);
    syncN = 1'b1;
    for (int i = 0; i <= 4*len + 4; i++) begin
      @(negedge clk);
      if (i == 0) chk("R3 comma on start edge", 8'hBC, 1'b1, 1'b0);
      else if (i <= 4*len) begin
        alignOct(i - 1, len, eo, ec);
        chk((kNew >= 0) ? "R7 length captured at start" : "R4 R5 R6 alignment octet",
            eo, ec, (i == 4*len));
      end else begin
        chk("R8 payload pass-through", payIn, 1'b0, 1'b1);
      end
      if (i == 0 && kNew >= 0) kMinus1 = KWB'(kNew);
      payIn = payIn * 8'd5 + 8'd17;
      if (i == abortAt) begin
        syncN = 1'b0;
        @(negedge clk);
        chk("R2 comma after request reasserted", 8'hBC, 1'b1, 1'b0);
        return;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 8'hBC, 1'b1, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", 8'hBC, 1'b1, 1'b0);
    for (int k = 0; k < (1 << KWB); k++) runSeq(k, -1, -1);
    runSeq(3, 4*FO*4 / 2, -1);
    runSeq(5, 4*FO*6 + 3, -1);
    runSeq(2, -1, 7);
    runSeq(6, -1, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule